// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits on the read path of a byte-wide nonvolatile store. While an internal page write or chip erase is running, it replaces normal array data with status bytes so that host software can poll for completion. It offers two polling schemes at once. The first is an inverted-data bit: bit 7 shows the complement of the last byte loaded, when the host reads at that byte's address. The second is a toggling bit: bit 6 alternates on every status read. Only the toggling bit is meaningful during a chip erase.

The block captures the address and data of the last byte loaded while idle. It arms itself when the busy input is first seen high. On arming it latches the operation type and presets the toggle so that the first status read returns 1. After busy drops, a settling window of `SETTLE_CYC` cycles follows. In that window bit 7 already carries true array data, while bits 6..0 still carry status values and the toggle is frozen. After the window, reads return plain array data. The timers that drive busy, and the array itself, are outside this block. The array's read data enters on `arr_rdata` for the address on `rd_addr` in the same cycle.

Top module: `wr_status_resp`

## Requirements
- R1: After synchronous reset, `rd_data` is 8'h00 and the block is idle, so reads return array data.
- R2: While idle, a read with `rd_en` high returns `arr_rdata`, as sampled with it, on `rd_data` one clock later.
- R3: During a page write, a read at the captured last-load address returns, in bit 7, the complement of bit 7 of the captured last-load data.
- R4: During busy, bit 6 of each status read alternates, starting at 1 on the first read after arming. The toggle advances only on reads, not on idle cycles.
- R5: During busy, bits 5..0 of a status byte equal `FILL[5:0]`. Bit 7 equals `FILL[7]` for page-write reads at any address other than the last-load address (default `FILL` = 8'h00).
- R6: During a chip erase (`busy_erase` high when armed), bit 7 equals `FILL[7]` even at the last-load address, and bit 6 toggles as in R4.
- R7: Byte loads are captured only while idle, and the latest one wins. Loads issued during busy or settling do not change the captured address or data.
- R8: Reads begin to see the settling window one cycle after busy is first sampled low, and the window lasts `SETTLE_CYC` reads. In that window a read returns {`arr_rdata[7]`, frozen toggle, `FILL[5:0]`}. The next read returns full array data.
- R9: Each arming, including one that starts during a settling window, presets the toggle so that the next status read returns bit 6 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Byte-load strobe |
| ld_addr | input | AW | Address of the loaded byte |
| ld_data | input | 8 | Loaded byte |
| busy | input | 1 | Internal operation in progress |
| busy_erase | input | 1 | Operation type at arming: 1 = chip erase, 0 = page write |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| arr_rdata | input | 8 | Array data for `rd_addr`, same cycle |
| rd_data | output | 8 | Read result, one cycle after `rd_en` |

## Verification
Every result lands on `rd_data` at the first rising edge after `rd_en` is sampled. The bench drives each request on a falling edge and reads the output on the next falling edge. Arming takes one edge: the bench raises busy, lets one edge pass, and only then issues status reads. The settling window is counted from the edge that first sees busy low. The bench therefore waits one edge after dropping busy, and then issues back-to-back reads, so that exactly `SETTLE_CYC` reads fall inside the window and the next one returns array data. The bench keeps its own model of the toggle and advances it only on the status reads it issues.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_BUSY   = 2'd1,
        PH_SETTLE = 2'd2
    } resp_phase_e;

    typedef enum logic {
        OPK_PAGE  = 1'b0,
        OPK_ERASE = 1'b1
    } op_kind_e;

    typedef struct packed {
        logic             hit;
        logic             last_b7;
        logic             tgl;
        logic [BYTE_W-1:0] arr;
        logic [BYTE_W-1:0] fill;
    } status_in_t;

    function automatic logic [BYTE_W-1:0] compose_status(
        input resp_phase_e ph,
        input op_kind_e    kind,
        input status_in_t  s
    );
        logic [BYTE_W-1:0] w;
        case (ph)
            PH_BUSY: begin
                w      = s.fill;
                w[6]   = s.tgl;
                w[7]   = (kind == OPK_PAGE && s.hit) ? ~s.last_b7 : s.fill[7];
            end
            PH_SETTLE: begin
                w      = s.fill;
                w[6]   = s.tgl;
                w[7]   = s.arr[7];
            end
            default: w = s.arr;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/wr_status_seq.sv
module wr_status_seq
    import wr_status_pkg::*;
#(
    parameter int SETTLE_CYC = 125
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        busy,
    input  logic        busy_erase,
    output resp_phase_e phase,
    output op_kind_e    kind,
    output logic        arm
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] settle_cnt;

    assign arm = busy && (phase != PH_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            kind       <= OPK_PAGE;
            settle_cnt <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (busy) begin
                        phase <= PH_BUSY;
                        kind  <= op_kind_e'(busy_erase);
                    end
                end
                PH_BUSY: begin
                    if (!busy) begin
                        phase      <= PH_SETTLE;
                        settle_cnt <= CW'(SETTLE_CYC - 1);
                    end
                end
                PH_SETTLE: begin
                    if (busy) begin
                        phase <= PH_BUSY;
                        kind  <= op_kind_e'(busy_erase);
                    end else if (settle_cnt == '0) begin
                        phase <= PH_IDLE;
                    end else begin
                        settle_cnt <= settle_cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_SETTLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SETTLE && !busy && settle_cnt != '0) |=> (phase == PH_SETTLE)); // R8
    AST_BUSY_ENTERS: assert property (@(posedge clk) disable iff (rst)
        (busy && phase != PH_BUSY) |=> (phase == PH_BUSY)); // R9

endmodule

// File: rtl/wr_status_capture.sv
module wr_status_capture #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data,
    output logic [AW-1:0] last_addr,
    output logic [7:0]    last_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr <= '0;
            last_data <= '0;
        end else if (ld_en && !hold) begin
            last_addr <= ld_addr;
            last_data <= ld_data;
        end
    end

    AST_LOAD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(last_addr) && $stable(last_data))); // R7

endmodule

// File: rtl/wr_status_toggle.sv
module wr_status_toggle (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic advance,
    output logic tgl
);
    always_ff @(posedge clk) begin
        if (rst)          tgl <= 1'b1;
        else if (arm)     tgl <= 1'b1;
        else if (advance) tgl <= ~tgl;
    end

    AST_TGL_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (advance && !arm) |=> (tgl != $past(tgl))); // R4
    AST_TGL_STILL: assert property (@(posedge clk) disable iff (rst)
        (!advance && !arm) |=> $stable(tgl)); // R4
    AST_TGL_PRESET: assert property (@(posedge clk) disable iff (rst)
        arm |=> tgl); // R9

endmodule

// File: rtl/wr_status_resp.sv
module wr_status_resp
    import wr_status_pkg::*;
#(
    parameter int         AW         = 16,
    parameter int         SETTLE_CYC = 125,
    parameter logic [7:0] FILL       = 8'h00
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data,
    input  logic          busy,
    input  logic          busy_erase,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [7:0]    arr_rdata,
    output logic [7:0]    rd_data
);
    resp_phase_e   phase;
    op_kind_e      kind;
    logic          arm;
    logic          tgl;
    logic [AW-1:0] last_addr;
    logic [7:0]    last_data;
    status_in_t    sin;

    wr_status_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .busy_erase (busy_erase),
        .phase      (phase),
        .kind       (kind),
        .arm        (arm)
    );

    wr_status_capture #(.AW(AW)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .hold      (phase != PH_IDLE),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .last_addr (last_addr),
        .last_data (last_data)
    );

    wr_status_toggle u_tgl (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .advance (rd_en && phase == PH_BUSY),
        .tgl     (tgl)
    );

    always_comb begin
        sin.hit     = (rd_addr == last_addr);
        sin.last_b7 = last_data[7];
        sin.tgl     = tgl;
        sin.arr     = arr_rdata;
        sin.fill    = FILL;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= compose_status(phase, kind, sin);
    end

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && phase == PH_IDLE) |=> (rd_data == $past(arr_rdata))); // R2
    AST_ERASE_NO_POLL: assert property (@(posedge clk) disable iff (rst)
        (rd_en && phase == PH_BUSY && kind == OPK_ERASE) |=> (rd_data[7] == FILL[7])); // R6
    AST_PAGE_POLL: assert property (@(posedge clk) disable iff (rst)
        (rd_en && phase == PH_BUSY && kind == OPK_PAGE && rd_addr == last_addr)
        |=> (rd_data[7] == ~$past(last_data[7]))); // R3
    AST_SETTLE_B7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && phase == PH_SETTLE) |=> (rd_data[7] == $past(arr_rdata[7]))); // R8

endmodule

// File: tb/wr_status_resp_test.sv
module wr_status_resp_test;
    localparam int AW     = 16;
    localparam int SETTLE = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;
    logic          busy = 1'b0;
    logic          busy_erase = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    arr_rdata;
    logic [7:0]    rd_data;

    int  n_chk = 0;
    int  n_bad = 0;
    logic tg;

    always #4 clk = ~clk;

    assign arr_rdata = rd_addr[7:0] ^ 8'h5A;

    wr_status_resp #(.AW(AW), .SETTLE_CYC(SETTLE), .FILL(8'h00)) uut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .busy(busy), .busy_erase(busy_erase), .rd_en(rd_en), .rd_addr(rd_addr),
        .arr_rdata(arr_rdata), .rd_data(rd_data)
    );

    function automatic logic [7:0] arr_of(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic do_load(input logic [AW-1:0] a, input logic [7:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic start_op(input logic erase);
        busy = 1'b1; busy_erase = erase;
        @(negedge clk);
        tg = 1'b1;
    endtask

    task automatic end_op();
        busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 reset value", rd_data, 8'h00);
        do_read(16'h0001, v);
        chk("R1/R2 idle read", v, arr_of(16'h0001));
        do_read(16'h00A0, v);
        chk("R2 idle read", v, arr_of(16'h00A0));
    endtask

    task automatic t_page();
        logic [7:0] v;
        do_load(16'h0120, 8'h11);
        do_load(16'h0124, 8'hA5);
        do_load(16'h0124, 8'h43);
        start_op(1'b0);
        for (int i = 0; i < 3; i++) begin
            do_read(16'h0124, v);
            chk("R3/R4/R5 page poll", v, {1'b1, tg, 6'b0});
            tg = ~tg;
        end
        do_load(16'h0300, 8'h00);
        do_read(16'h0124, v);
        chk("R7 load during busy ignored", v, {1'b1, tg, 6'b0});
        tg = ~tg;
        do_read(16'h0300, v);
        chk("R5/R7 other address", v, {1'b0, tg, 6'b0});
        tg = ~tg;
        end_op();
        for (int i = 0; i < SETTLE; i++) begin
            do_read(16'h0124, v);
            chk("R8 settle window", v, {arr_of(16'h0124)[7], tg, 6'b0});
        end
        do_read(16'h0124, v);
        chk("R8 after settle", v, arr_of(16'h0124));
    endtask

    task automatic t_erase();
        logic [7:0] v;
        do_load(16'h0055, 8'h00);
        start_op(1'b1);
        for (int i = 0; i < 3; i++) begin
            do_read(16'h0055, v);
            chk("R6/R9 erase status", v, {1'b0, tg, 6'b0});
            tg = ~tg;
        end
        end_op();
        do_read(16'h0080, v);
        chk("R8 settle true bit7", v, {1'b1, tg, 6'b0});
        repeat (SETTLE) @(negedge clk);
        do_read(16'h0055, v);
        chk("R8 erase done", v, arr_of(16'h0055));
    endtask

    task automatic t_rearm();
        logic [7:0] v;
        do_load(16'h0010, 8'h80);
        start_op(1'b0);
        do_read(16'h0010, v);
        chk("R9 first read", v, 8'h40);
        tg = ~tg;
        repeat (3) @(negedge clk);
        do_read(16'h0010, v);
        chk("R4 no advance without read", v, {1'b0, tg, 6'b0});
        tg = ~tg;
        do_read(16'h0010, v);
        chk("R4 advance on read", v, {1'b0, tg, 6'b0});
        tg = ~tg;
        end_op();
        do_read(16'h0010, v);
        chk("R8 settle before rearm", v, {arr_of(16'h0010)[7], tg, 6'b0});
        start_op(1'b0);
        do_read(16'h0010, v);
        chk("R9 rearm in settle", v, 8'h40);
        end_op();
        repeat (SETTLE + 1) @(negedge clk);
        do_read(16'h0010, v);
        chk("R2 back to array", v, arr_of(16'h0010));
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        tg = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_page();
        t_erase();
        t_rearm();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule